// File: doc/BRIEF.md
# Alarm Comparator with One-Shot and Periodic Modes

This block watches one of two free-running 52-bit tick counts and raises an interrupt when that count reaches a programmed alarm point. It has two modes. In one-shot mode it fires once, when the selected count is at or beyond a programmed 52-bit target. In periodic mode it fires every N ticks, where N is a 26-bit period. The block sets its own first alarm point to the count at arm time plus N, and moves the alarm point forward by N each time it fires.

Software writes the target halves and the mode word into shadow registers. Nothing it writes there changes the comparison until a one-cycle load strobe copies the shadow contents into the active state and arms the comparator. The alarm point in use can always be read back. The interrupt has a sticky raw bit, an enable, and a clear strobe, and the status output is the raw bit gated by the enable. Three of these blocks, together with the two counters, make up a system timer.

Top module: `alarm_cmp`

## Requirements
- R1: Pulses on `wr_lo`, `wr_hi` and `wr_cfg` change only the shadow copies. `real_lo`/`real_hi` and the active mode stay as they are until `load` is pulsed.
- R2: A `load` with the shadow mode one-shot (`cfg_periodic`=0) sets the alarm point {`real_hi`,`real_lo`} to the shadow target {hi,lo} on the next clock edge and arms the comparator.
- R3: A `load` with the shadow mode periodic (`cfg_periodic`=1) sets the alarm point to the selected count at that edge plus the shadow period, modulo 2^52.
- R4: In one-shot mode, a selected count at or above the alarm point while armed and enabled sets `irq_raw` on the next edge and disarms the comparator. It does not fire again until the next `load`.
- R5: In periodic mode with a nonzero period, every match sets `irq_raw` and advances the alarm point by the period, modulo 2^52.
- R6: In periodic mode with a period of zero, the comparator never fires.
- R7: While `work_en` is 0, no match is declared and the alarm point does not change except by `load`.
- R8: The unit select (`cfg_use_b`) compares against `cnt_b` when 1 and against `cnt_a` when 0.
- R9: `irq_clr` clears `irq_raw` on the next edge. If a match occurs in the same cycle as `irq_clr`, the match wins and `irq_raw` stays 1.
- R10: `irq_st` is 1 exactly when both `irq_raw` and `irq_en` are 1.
- R11: After reset the alarm point is 0, `irq_raw` is 0 and the comparator is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_a | input | 52 | Count of timer unit A |
| cnt_b | input | 52 | Count of timer unit B |
| work_en | input | 1 | Comparator enable |
| wr_lo | input | 1 | Write strobe for the shadow target, low part |
| lo_data | input | 32 | Shadow target low 32 bits |
| wr_hi | input | 1 | Write strobe for the shadow target, high part |
| hi_data | input | 20 | Shadow target high 20 bits |
| wr_cfg | input | 1 | Write strobe for the shadow mode word |
| cfg_period | input | 26 | Shadow period |
| cfg_periodic | input | 1 | Shadow mode: 1 periodic, 0 one-shot |
| cfg_use_b | input | 1 | Shadow unit select: 1 uses cnt_b, 0 uses cnt_a |
| load | input | 1 | One-cycle strobe that applies the shadow state and arms the comparator |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Write-one clear strobe for the raw bit |
| real_lo | output | 32 | Alarm point in use, low 32 bits |
| real_hi | output | 20 | Alarm point in use, high 20 bits |
| irq_raw | output | 1 | Sticky raw interrupt |
| irq_st | output | 1 | Raw interrupt gated by enable |

## Verification
The vector table arms the comparator in each mode and with each counter source. It then steps one enabled cycle and checks the alarm point before and after that cycle, together with the raw bit. The counts are chosen to separate the cases:
- a count equal to the target from one a tick short, which catches an off-by-one in the compare;
- a full-range count against a target with its top bit set, which catches a truncated compare;
- a periodic arm near the top of the range, which shows that the sum wraps modulo 2^52;
- a zero period against a count that would otherwise match, which shows the zero-period guard.

Directed sequences then run a periodic alarm through several matches, and cover set against clear in the same cycle, enable gating, one-shot disarm, shadow isolation before `load`, and a counter above the target on the unselected source.

// File: rtl/alarm_cmp.sv
module alarm_cmp #(
  parameter int CNT_W = 52,
  parameter int LO_W  = 32,
  parameter int PER_W = 26
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W-1:0]   cnt_a,
  input  logic [CNT_W-1:0]   cnt_b,
  input  logic               work_en,
  input  logic               wr_lo,
  input  logic [LO_W-1:0]    lo_data,
  input  logic               wr_hi,
  input  logic [CNT_W-LO_W-1:0] hi_data,
  input  logic               wr_cfg,
  input  logic [PER_W-1:0]   cfg_period,
  input  logic               cfg_periodic,
  input  logic               cfg_use_b,
  input  logic               load,
  input  logic               irq_en,
  input  logic               irq_clr,
  output logic [LO_W-1:0]    real_lo,
  output logic [CNT_W-LO_W-1:0] real_hi,
  output logic               irq_raw,
  output logic               irq_st
);
  localparam int HI_W  = CNT_W - LO_W;
  localparam int PAD_W = CNT_W - PER_W;

  logic [LO_W-1:0]  sh_lo;
  logic [HI_W-1:0]  sh_hi;
  logic [PER_W-1:0] sh_per;
  logic             sh_mode, sh_sel;

  logic [PER_W-1:0] act_period;
  logic             act_mode, act_sel;
  logic [CNT_W-1:0] real_tgt;
  logic             armed;

  logic [CNT_W-1:0] cnt_now, cnt_arm;
  logic             hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_lo   <= '0;
      sh_hi   <= '0;
      sh_per  <= '0;
      sh_mode <= 1'b0;
      sh_sel  <= 1'b0;
    end else begin
      if (wr_lo)  sh_lo <= lo_data;
      if (wr_hi)  sh_hi <= hi_data;
      if (wr_cfg) begin
        sh_per  <= cfg_period;
        sh_mode <= cfg_periodic;
        sh_sel  <= cfg_use_b;
      end
    end
  end

  assign cnt_now = act_sel ? cnt_b : cnt_a;
  assign cnt_arm = sh_sel  ? cnt_b : cnt_a;

  assign hit = work_en && armed && (cnt_now >= real_tgt) &&
               (!act_mode || (act_period != '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_period <= '0;
      act_mode   <= 1'b0;
      act_sel    <= 1'b0;
      real_tgt   <= '0;
      armed      <= 1'b0;
    end else if (load) begin
      act_period <= sh_per;
      act_mode   <= sh_mode;
      act_sel    <= sh_sel;
      real_tgt   <= sh_mode ? cnt_arm + {{PAD_W{1'b0}}, sh_per} : {sh_hi, sh_lo};
      armed      <= 1'b1;
    end else if (hit) begin
      if (act_mode) real_tgt <= real_tgt + {{PAD_W{1'b0}}, act_period};
      else          armed    <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq_raw <= 1'b0;
    else if (hit)     irq_raw <= 1'b1;
    else if (irq_clr) irq_raw <= 1'b0;
  end

  assign irq_st  = irq_raw & irq_en;
  assign real_lo = real_tgt[LO_W-1:0];
  assign real_hi = real_tgt[CNT_W-1:LO_W];
endmodule

// File: rtl/alarm_cmp_chk.sv
module alarm_cmp_chk #(
  parameter int CNT_W = 52,
  parameter int PER_W = 26
) (
  input logic             clk,
  input logic             rst_n,
  input logic             work_en,
  input logic             load,
  input logic             irq_clr,
  input logic             irq_raw,
  input logic [CNT_W-1:0] real_tgt,
  input logic             act_mode,
  input logic [PER_W-1:0] act_period,
  input logic             armed
);
  a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!work_en && !load) |=> $stable(real_tgt));

  a_r7_rise_needs_work: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_raw) |-> $past(work_en));

  a_r9_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_raw) |-> $past(irq_clr));

  a_r6_zero_period_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mode && act_period == '0) |=> !$rose(irq_raw));

  a_r5_advance: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_raw) && !$past(load) && $past(act_mode)) |->
      (real_tgt == CNT_W'($past(real_tgt) + {{(CNT_W-PER_W){1'b0}}, $past(act_period)})));

  a_r4_oneshot_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_raw) && !$past(load) && !$past(act_mode)) |-> !armed);
endmodule

bind alarm_cmp alarm_cmp_chk #(.CNT_W(CNT_W), .PER_W(PER_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .work_en(work_en), .load(load),
  .irq_clr(irq_clr), .irq_raw(irq_raw), .real_tgt(real_tgt),
  .act_mode(act_mode), .act_period(act_period), .armed(armed)
);

// File: tb/alarm_cmp_tb_top.sv
module alarm_cmp_tb_top;
  localparam int CW = 52;
  localparam int NV = 6;

  logic clk = 0, rst_n = 0;
  logic [CW-1:0] cnt_a = '0, cnt_b = '0;
  logic work_en = 0, wr_lo = 0, wr_hi = 0, wr_cfg = 0, load = 0;
  logic [31:0] lo_data = '0;
  logic [19:0] hi_data = '0;
  logic [25:0] cfg_period = '0;
  logic cfg_periodic = 0, cfg_use_b = 0, irq_en = 0, irq_clr = 0;
  logic [31:0] real_lo;
  logic [19:0] real_hi;
  logic irq_raw, irq_st;

  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  alarm_cmp dut_i (.*);

  localparam logic [CW-1:0] V_A   [NV] = '{52'd500, 52'd499, 52'd0, 52'd0, 52'hF_FFFF_FFFF_FFF0, 52'd100};
  localparam logic [CW-1:0] V_B   [NV] = '{52'd0, 52'd0, 52'hF_FFFF_FFFF_FFFF, 52'd1000, 52'd0, 52'd0};
  localparam logic          V_SEL [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};
  localparam logic          V_PM  [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};
  localparam logic [25:0]   V_PER [NV] = '{26'd0, 26'd0, 26'd0, 26'd16, 26'h3FF_FFFF, 26'd0};
  localparam logic [CW-1:0] V_TGT [NV] = '{52'd500, 52'd500, 52'h8_0000_0000_0000, 52'd7, 52'd7, 52'd7};
  localparam logic          V_HIT [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr_target(input logic [CW-1:0] t);
    lo_data = t[31:0]; hi_data = t[51:32];
    wr_lo = 1; wr_hi = 1; step(); wr_lo = 0; wr_hi = 0;
  endtask

  task automatic wr_mode(input logic pm, input logic sel, input logic [25:0] per);
    cfg_periodic = pm; cfg_use_b = sel; cfg_period = per;
    wr_cfg = 1; step(); wr_cfg = 0;
  endtask

  task automatic pulse_load();  load = 1; step(); load = 0; endtask
  task automatic pulse_clr();   irq_clr = 1; step(); irq_clr = 0; endtask

  function automatic logic [63:0] rt();
    return {12'd0, real_hi, real_lo};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] exp_rt;
    @(negedge clk); @(negedge clk);
    chk("R11 reset alarm point", rt(), 0);
    chk("R11 reset raw", irq_raw, 0);
    rst_n = 1; step();
    work_en = 1; cnt_a = 52'd5; step();
    chk("R11 disarmed after reset", irq_raw, 0);
    work_en = 0;

    for (int i = 0; i < NV; i++) begin
      cnt_a = V_A[i]; cnt_b = V_B[i];
      wr_target(V_TGT[i]);
      wr_mode(V_PM[i], V_SEL[i], V_PER[i]);
      pulse_load();
      pulse_clr();
      exp_rt = V_PM[i] ? (V_SEL[i] ? V_B[i] : V_A[i]) + {26'd0, V_PER[i]} : V_TGT[i];
      chk(V_PM[i] ? "R3 periodic arm" : "R2 one-shot arm", rt(), {12'd0, exp_rt});
      work_en = 1; step(); work_en = 0;
      chk(V_PM[i] ? "R5/R6 vector raw" : "R4/R8 vector raw", irq_raw, V_HIT[i]);
      if (V_HIT[i] && V_PM[i]) exp_rt = exp_rt + {26'd0, V_PER[i]};
      chk("R5 vector alarm point after", rt(), {12'd0, exp_rt});
    end

    // periodic run
    cnt_a = 0; cnt_b = 0;
    wr_mode(1, 0, 26'd10); pulse_load(); pulse_clr();
    chk("R3 periodic from zero", rt(), 10);
    work_en = 1; cnt_a = 5; step();
    chk("R5 no match below", irq_raw, 0);
    cnt_a = 10; step();
    chk("R5 first match raw", irq_raw, 1);
    chk("R5 advanced to 20", rt(), 20);
    cnt_a = 20; irq_clr = 1; step(); irq_clr = 0;
    chk("R9 set wins over clear", irq_raw, 1);
    chk("R5 advanced to 30", rt(), 30);
    cnt_a = 25; pulse_clr();
    chk("R9 clear", irq_raw, 0);
    cnt_a = 30; step();
    chk("R5 third match", irq_raw, 1);
    irq_en = 0; #1;
    chk("R10 status gated off", irq_st, 0);
    irq_en = 1; #1;
    chk("R10 status on", irq_st, 1);
    irq_en = 0;

    // zero period
    work_en = 0;
    wr_mode(1, 0, 26'd0); pulse_load(); pulse_clr();
    chk("R3 zero period arm", rt(), 30);
    work_en = 1; repeat (3) step();
    chk("R6 zero period silent", irq_raw, 0);
    work_en = 0;

    // one-shot, shadow isolation
    wr_target(52'd50); wr_mode(0, 0, 26'd0);
    chk("R1 shadow not applied", rt(), 30);
    pulse_load(); pulse_clr();
    chk("R2 target applied", rt(), 50);
    work_en = 1; cnt_a = 60; step();
    chk("R4 one-shot fires", irq_raw, 1);
    pulse_clr(); repeat (3) step();
    chk("R4 no refire", irq_raw, 0);
    chk("R4 alarm point held", rt(), 50);

    // work enable off
    work_en = 0;
    wr_target(52'd70); pulse_load(); pulse_clr();
    cnt_a = 80; repeat (3) step();
    chk("R7 disabled no fire", irq_raw, 0);
    chk("R7 alarm point held", rt(), 70);

    // unit select
    wr_mode(0, 1, 26'd0); pulse_load(); pulse_clr();
    cnt_a = 1000; cnt_b = 0; work_en = 1; step();
    chk("R8 other unit ignored", irq_raw, 0);
    cnt_b = 70; step();
    chk("R8 selected unit fires", irq_raw, 1);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule